// File: doc/BRIEF.md
# Indirect register bridge

This block is a memory-mapped slave placed inside a host register window. It lets the host reach a second register space that is not mapped into that window. The host sees a mailbox of four 32-bit words. One word is the command word. The other three hold the target address, the write data and the returned read data.

To start a transfer, the host loads the address (and, for a write, the write data) and then sets a read or write bit in the command word. The bridge issues exactly one request on a downstream request/ready/response-valid port. When the response arrives, it sets an acknowledge flag. The host then closes the transfer by writing zero to the command word.

Targets beyond the downstream span are never forwarded: the bridge acknowledges them at once, and such a read yields zero. Host polling, timeouts and the contents of the downstream space belong to the surrounding system, not to this block.

Top module: `ibr_bridge`

## Requirements
- R1: The mailbox starts at window byte address 0x400 (MBX_BASE). Offset 0x0 is the command word, 0x4 the target address, 0x8 the read data and 0xC the write data; byte bits [1:0] are ignored. A read of any other window address, or any access with hst_rd low, returns zero on hst_rdata; writes to other addresses change nothing.
- R2: In idle, a command write with bit 1 set and bit 0 clear starts a write. After the downstream response, the command word reads 0x6. While the transfer is pending, it reads 0x2, and dn_we is 1 with dn_addr/dn_wdata equal to the address and write-data words.
- R3: In idle, a command write with bit 0 set and bit 1 clear starts a read. The response data is latched into the read-data word at the same clock edge that sets the acknowledge flag, so the command word reads 0x5 only when offset 0x8 already holds the returned value. While pending, the command word reads 0x1 and dn_we is 0.
- R4: dn_req is high from the cycle after the command write until the cycle in which dn_ready is seen, and dn_addr, dn_we and dn_wdata stay unchanged over that time. Each transfer produces exactly one accepted request. dn_rvalid is only taken in a cycle after acceptance.
- R5: Only the bridge sets command bit 2. A host write with bit 2 set, alone or in idle, sets nothing, and host writes never clear it except as stated in R6.
- R6: In the acknowledged state, a host write of exactly zero to the command word returns the bridge to idle, and the command word then reads 0.
- R7: A nonzero command write while a transfer is pending or acknowledged is ignored: no new request is issued and the command word keeps its value.
- R8: A command write with both bits 0 and 1 set (or neither) in idle is a no-op: the command word stays 0 and no request is issued.
- R9: A target address with any bit at or above DN_AW set (above 0xFFF by default) issues no downstream request. It is acknowledged on the next clock edge, and for a read the read-data word becomes zero. Address 0xFFC is still forwarded.
- R10: The address and write-data words read back what the host last wrote. Host writes to them are ignored unless the bridge is idle.
- R11: A synchronous reset clears all mailbox words to zero and returns the bridge to idle.
- R12: A write of zero to the command word while a request is pending does not abort it; the transfer still completes and sets the acknowledge flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hst_wr | input | 1 | Host write strobe, one access per cycle |
| hst_rd | input | 1 | Host read strobe |
| hst_addr | input | HOST_AW | Host byte address within the window |
| hst_wdata | input | DATA_W | Host write data |
| hst_rdata | output | DATA_W | Host read data, combinational from address and strobe |
| dn_req | output | 1 | Downstream request valid |
| dn_we | output | 1 | Downstream request is a write |
| dn_addr | output | DN_AW | Downstream register address |
| dn_wdata | output | DATA_W | Downstream write data |
| dn_ready | input | 1 | Downstream accepts the request |
| dn_rvalid | input | 1 | Downstream response valid (read data or write done) |
| dn_rdata | input | DATA_W | Downstream read data |

## Verification
The bench builds the bridge with a 12-bit host window, 32-bit data, a 12-bit downstream span and the mailbox at 0x400. With these values, the last in-span address 0xFFC and the first out-of-span address 0x1000 can both be reached with ordinary host writes. A downstream responder with varying ready and response delays, from zero to two cycles each, makes both the zero-wait acceptance and the multi-cycle hold of the request appear. Stray command writes land in every busy state because the responder's minimum response latency leaves at least three busy cycles after each start.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_ACK  = 2'd3
  } ibr_state_e;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_CMD   = 3'd1,
    SEL_ADDR  = 3'd2,
    SEL_RDATA = 3'd3,
    SEL_WDATA = 3'd4
  } ibr_sel_e;

  localparam int unsigned CMD_RD_BIT  = 0;
  localparam int unsigned CMD_WR_BIT  = 1;
  localparam int unsigned CMD_ACK_BIT = 2;

  // Which mailbox word a host byte address hits; byte lanes ignored.
  function automatic ibr_sel_e ibr_decode(input logic [63:0] addr,
                                          input logic [63:0] base);
    if (addr < base || (addr - base) > 64'hF) return SEL_NONE;
    case (2'((addr - base) >> 2))
      2'd0:    return SEL_CMD;
      2'd1:    return SEL_ADDR;
      2'd2:    return SEL_RDATA;
      default: return SEL_WDATA;
    endcase
  endfunction

  // Target lies inside a downstream space of 2**aw registers' byte span.
  function automatic logic ibr_in_span(input logic [63:0] addr,
                                       input int unsigned aw);
    return (addr >> aw) == 64'd0;
  endfunction

  // Exactly one of read/write requested.
  function automatic logic ibr_cmd_ok(input logic rd_bit, input logic wr_bit);
    return rd_bit ^ wr_bit;
  endfunction

endpackage

// File: rtl/ibr_host_if.sv
module ibr_host_if
  import ibr_pkg::*;
#(
  parameter int unsigned HOST_AW  = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned MBX_BASE = 32'h400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_wr,
  input  logic               hst_rd,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [DATA_W-1:0]  cmd_view,
  input  logic [DATA_W-1:0]  addr_q,
  input  logic [DATA_W-1:0]  rdata_q,
  input  logic [DATA_W-1:0]  wdata_q,
  output logic               cmd_wr_evt,
  output logic               addr_wr_evt,
  output logic               wdata_wr_evt,
  output logic [DATA_W-1:0]  hst_rdata
);

  ibr_sel_e sel;

  assign sel          = ibr_decode(64'(hst_addr), 64'(MBX_BASE));
  assign cmd_wr_evt   = hst_wr && (sel == SEL_CMD);
  assign addr_wr_evt  = hst_wr && (sel == SEL_ADDR);
  assign wdata_wr_evt = hst_wr && (sel == SEL_WDATA);

  always_comb begin
    hst_rdata = '0;
    if (hst_rd) begin
      unique case (sel)
        SEL_CMD:   hst_rdata = cmd_view;
        SEL_ADDR:  hst_rdata = addr_q;
        SEL_RDATA: hst_rdata = rdata_q;
        SEL_WDATA: hst_rdata = wdata_q;
        default:   hst_rdata = '0;
      endcase
    end
  end

  // R1: a host write hits at most one mailbox word
  p_one_word_r1: assert property (@(posedge clk) disable iff (rst)
    hst_wr |-> $onehot0({cmd_wr_evt, addr_wr_evt, wdata_wr_evt}));

  // R1: reads outside the mailbox return zero
  p_hole_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (hst_rd && sel == SEL_NONE) |-> (hst_rdata == '0));

endmodule

// File: rtl/ibr_xfer_fsm.sv
module ibr_xfer_fsm
  import ibr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DN_AW  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_evt,
  input  logic              addr_wr_evt,
  input  logic              wdata_wr_evt,
  input  logic [DATA_W-1:0] wr_value,
  input  logic              dn_ready,
  input  logic              dn_rvalid,
  input  logic [DATA_W-1:0] dn_rdata,
  output logic [DATA_W-1:0] cmd_view,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              dn_req,
  output logic              dn_we,
  output logic [DN_AW-1:0]  dn_addr,
  output logic [DATA_W-1:0] dn_wdata
);

  localparam int unsigned PAD_W = DATA_W - 3;

  ibr_state_e state_q, state_d;
  logic       op_rd_q;

  // Named events for the checks below
  logic is_idle, tgt_ok, start_evt, oob_evt, accept_evt, resp_evt, clear_evt;

  assign is_idle    = (state_q == ST_IDLE);
  assign tgt_ok     = ibr_in_span(64'(addr_q), DN_AW);
  assign start_evt  = is_idle && cmd_wr_evt &&
                      ibr_cmd_ok(wr_value[CMD_RD_BIT], wr_value[CMD_WR_BIT]);
  assign oob_evt    = start_evt && !tgt_ok;
  assign accept_evt = (state_q == ST_REQ) && dn_ready;
  assign resp_evt   = (state_q == ST_WAIT) && dn_rvalid;
  assign clear_evt  = (state_q == ST_ACK) && cmd_wr_evt && (wr_value == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_evt)  state_d = tgt_ok ? ST_REQ : ST_ACK;
      ST_REQ:  if (accept_evt) state_d = ST_WAIT;
      ST_WAIT: if (resp_evt)   state_d = ST_ACK;
      ST_ACK:  if (clear_evt)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      op_rd_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (start_evt) op_rd_q <= wr_value[CMD_RD_BIT];
      if (is_idle && addr_wr_evt)  addr_q  <= wr_value;
      if (is_idle && wdata_wr_evt) wdata_q <= wr_value;
      if (oob_evt && wr_value[CMD_RD_BIT]) rdata_q <= '0;
      else if (resp_evt && op_rd_q)        rdata_q <= dn_rdata;
    end
  end

  logic active, ack_flag;
  assign active   = !is_idle;
  assign ack_flag = (state_q == ST_ACK);
  assign cmd_view = {{PAD_W{1'b0}}, ack_flag, active && !op_rd_q, active && op_rd_q};

  assign dn_req   = (state_q == ST_REQ);
  assign dn_we    = !op_rd_q;
  assign dn_addr  = addr_q[DN_AW-1:0];
  assign dn_wdata = wdata_q;

  // R4: request and its payload hold until accepted
  p_hold_req_r4: assert property (@(posedge clk) disable iff (rst)
    (dn_req && !dn_ready) |=> (dn_req && $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)));

  // R5: acknowledge appears only after a response or an out-of-span start
  p_ack_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_view[CMD_ACK_BIT]) |-> $past(resp_evt || oob_evt));

  // R6: clearing returns the command word to zero
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (rst)
    clear_evt |=> (cmd_view == '0));

  // R7: nonzero command writes after acknowledge change nothing
  p_ack_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (ack_flag && cmd_wr_evt && wr_value != '0) |=> $stable(cmd_view));

  // R8: both direction bits at once never leave idle
  p_both_noop_r8: assert property (@(posedge clk) disable iff (rst)
    (is_idle && cmd_wr_evt && wr_value[1:0] == 2'b11) |=> (cmd_view == '0));

  // R9: out-of-span targets are never requested
  p_span_only_r9: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> tgt_ok);

  // R10: address and write data frozen outside idle
  p_frozen_r10: assert property (@(posedge clk) disable iff (rst)
    !is_idle |=> ($stable(addr_q) && $stable(wdata_q)));

  // R2: the direction bits of the command word are exclusive
  p_dir_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_view[1:0]));

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
  import ibr_pkg::*;
#(
  parameter int unsigned HOST_AW  = 12,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned DN_AW    = 12,
  parameter int unsigned MBX_BASE = 32'h400
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hst_wr,
  input  logic               hst_rd,
  input  logic [HOST_AW-1:0] hst_addr,
  input  logic [DATA_W-1:0]  hst_wdata,
  output logic [DATA_W-1:0]  hst_rdata,
  output logic               dn_req,
  output logic               dn_we,
  output logic [DN_AW-1:0]   dn_addr,
  output logic [DATA_W-1:0]  dn_wdata,
  input  logic               dn_ready,
  input  logic               dn_rvalid,
  input  logic [DATA_W-1:0]  dn_rdata
);

  logic              cmd_wr_evt, addr_wr_evt, wdata_wr_evt;
  logic [DATA_W-1:0] cmd_view, addr_q, wdata_q, rdata_q;

  ibr_host_if #(
    .HOST_AW (HOST_AW),
    .DATA_W  (DATA_W),
    .MBX_BASE(MBX_BASE)
  ) u_host (
    .clk         (clk),
    .rst         (rst),
    .hst_wr      (hst_wr),
    .hst_rd      (hst_rd),
    .hst_addr    (hst_addr),
    .cmd_view    (cmd_view),
    .addr_q      (addr_q),
    .rdata_q     (rdata_q),
    .wdata_q     (wdata_q),
    .cmd_wr_evt  (cmd_wr_evt),
    .addr_wr_evt (addr_wr_evt),
    .wdata_wr_evt(wdata_wr_evt),
    .hst_rdata   (hst_rdata)
  );

  ibr_xfer_fsm #(
    .DATA_W(DATA_W),
    .DN_AW (DN_AW)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr_evt  (cmd_wr_evt),
    .addr_wr_evt (addr_wr_evt),
    .wdata_wr_evt(wdata_wr_evt),
    .wr_value    (hst_wdata),
    .dn_ready    (dn_ready),
    .dn_rvalid   (dn_rvalid),
    .dn_rdata    (dn_rdata),
    .cmd_view    (cmd_view),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .rdata_q     (rdata_q),
    .dn_req      (dn_req),
    .dn_we       (dn_we),
    .dn_addr     (dn_addr),
    .dn_wdata    (dn_wdata)
  );

  // R11: reset leaves the bridge idle with an empty command word
  p_reset_idle_r11: assert property (@(posedge clk)
    rst |=> (hst_rd || !hst_rd) && !dn_req && (cmd_view == '0) && (addr_q == '0));

endmodule

// File: tb/sim_ibr_bridge.sv
module sim_ibr_bridge;
  localparam int HOST_AW = 12;
  localparam int DATA_W  = 32;
  localparam int DN_AW   = 12;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst = 1'b1;
  logic               hst_wr = 1'b0, hst_rd = 1'b0;
  logic [HOST_AW-1:0] hst_addr = '0;
  logic [DATA_W-1:0]  hst_wdata = '0;
  logic [DATA_W-1:0]  hst_rdata;
  logic               dn_req, dn_we;
  logic [DN_AW-1:0]   dn_addr;
  logic [DATA_W-1:0]  dn_wdata;
  logic               dn_ready = 1'b0, dn_rvalid = 1'b0;
  logic [DATA_W-1:0]  dn_rdata = '0;

  ibr_bridge #(.HOST_AW(HOST_AW), .DATA_W(DATA_W), .DN_AW(DN_AW), .MBX_BASE(32'h400)) u0 (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .dn_req(dn_req), .dn_we(dn_we),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_ready(dn_ready), .dn_rvalid(dn_rvalid),
    .dn_rdata(dn_rdata));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_st = 0;       // 0 idle, 1 requesting, 2 waiting, 3 acknowledged
  bit          m_rd = 0;
  logic [31:0] m_addr = 0, m_wd = 0, m_rdat = 0;

  function automatic int m_sel(logic [HOST_AW-1:0] a);
    int x = int'(a);
    if (x >= 'h400 && x < 'h410) return (x - 'h400) / 4 + 1;
    return 0;
  endfunction

  function automatic logic [31:0] m_cmd();
    if (m_st == 0) return 0;
    return {29'd0, m_st == 3, !m_rd, m_rd};
  endfunction

  function automatic logic [31:0] m_host_rd();
    if (!hst_rd) return 0;
    case (m_sel(hst_addr))
      1: return m_cmd();
      2: return m_addr;
      3: return m_rdat;
      4: return m_wd;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int s;
    s = m_sel(hst_addr);
    if (rst) begin
      m_st = 0; m_rd = 0; m_addr = 0; m_wd = 0; m_rdat = 0;
    end else begin
      case (m_st)
        0: begin
          if (hst_wr && s == 1 && (hst_wdata[0] != hst_wdata[1])) begin
            m_rd = hst_wdata[0];
            if (m_addr >= 32'd4096) begin
              m_st = 3;
              if (m_rd) m_rdat = 0;
            end else m_st = 1;
          end else if (hst_wr && s == 2) m_addr = hst_wdata;
          else if (hst_wr && s == 4) m_wd = hst_wdata;
        end
        1: if (dn_ready) m_st = 2;
        2: if (dn_rvalid) begin m_st = 3; if (m_rd) m_rdat = dn_rdata; end
        default: if (hst_wr && s == 1 && hst_wdata == 0) m_st = 0;
      endcase
    end
  end

  task automatic compare_all();
    check(dn_req === (m_st == 1), "R4 dn_req", 32'(dn_req), 32'(m_st == 1));
    if (m_st == 1) begin
      check(dn_addr === m_addr[DN_AW-1:0], "R4 dn_addr", 32'(dn_addr), 32'(m_addr[DN_AW-1:0]));
      check(dn_we === !m_rd, "R2 dn_we", 32'(dn_we), 32'(!m_rd));
      check(dn_wdata === m_wd, "R2 dn_wdata", dn_wdata, m_wd);
    end
    check(hst_rdata === m_host_rd(), "R1 host read data", hst_rdata, m_host_rd());
  endtask

  // ---------------- downstream responder ----------------
  logic [31:0] mem [int unsigned];
  int          ph = 0, cnt = 0, seed = 0, ops = 0;
  logic [11:0] r_addr = 0;
  bit          r_we = 0;
  logic [31:0] r_wd = 0;

  function automatic logic [31:0] rd_mem(logic [11:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return 32'h5A00_0000 | 32'(a);
  endfunction

  task automatic responder();
    if (rst) begin
      ph = 0; dn_ready = 0; dn_rvalid = 0;
    end else if (ph == 2) begin
      if (dn_rvalid) begin dn_rvalid = 0; ph = 0; end
      else if (cnt == 0) begin
        dn_rvalid = 1;
        dn_rdata  = r_we ? 32'hDEAD_0000 : rd_mem(r_addr);
      end else cnt--;
    end else begin
      if (ph == 0 && dn_req) begin ph = 1; cnt = seed % 3; seed++; end
      if (ph == 1) begin
        if (dn_ready) begin
          dn_ready = 0; ops++;
          if (r_we) mem[int'(r_addr)] = r_wd;
          ph = 2; cnt = (seed / 2) % 3; seed++;
        end else if (cnt == 0) begin
          dn_ready = 1; r_addr = dn_addr; r_we = dn_we; r_wd = dn_wdata;
        end else cnt--;
      end
    end
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
    responder();
  endtask

  task automatic host_write(logic [11:0] a, logic [31:0] v);
    hst_wr = 1; hst_rd = 0; hst_addr = a; hst_wdata = v;
    tick();
    hst_wr = 0;
  endtask

  task automatic host_read(logic [11:0] a, output logic [31:0] v);
    hst_rd = 1; hst_wr = 0; hst_addr = a;
    tick();
    v = hst_rdata;
    hst_rd = 0;
  endtask

  task automatic wait_ack(output logic [31:0] c);
    c = 0;
    for (int i = 0; i < 30; i++) begin
      host_read(12'h400, c);
      if (c[2]) break;
    end
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] v, output logic [31:0] c);
    host_write(12'h40C, v);
    host_write(12'h404, a);
    host_write(12'h400, 32'h2);
    wait_ack(c);
  endtask

  task automatic do_read(logic [31:0] a, output logic [31:0] c, output logic [31:0] d);
    host_write(12'h404, a);
    host_write(12'h400, 32'h1);
    wait_ack(c);
    host_read(12'h408, d);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R2 watchdog actual=hung expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] c, d;
    int o;
    tick(); tick();
    rst = 0;
    tick();

    // R11: reset state
    host_read(12'h400, c); check(c == 0, "R11 cmd after reset", c, 0);
    host_read(12'h404, c); check(c == 0, "R11 addr after reset", c, 0);
    host_read(12'h408, c); check(c == 0, "R11 rdata after reset", c, 0);
    host_read(12'h40C, c); check(c == 0, "R11 wdata after reset", c, 0);

    // R1: holes read zero, write to hole ignored, strobe-less read is zero
    host_write(12'h414, 32'hFFFF_FFFF);
    host_read(12'h410, c); check(c == 0, "R1 hole read", c, 0);
    host_read(12'h000, c); check(c == 0, "R1 low hole read", c, 0);
    host_write(12'h404, 32'h0000_0123);
    hst_addr = 12'h404; tick(); check(hst_rdata == 0, "R1 no strobe", hst_rdata, 0);
    host_read(12'h406, c); check(c == 32'h123, "R10 addr readback lane", c, 32'h123);

    // R2: write transfer
    o = ops;
    do_write(32'h10, 32'hCAFE_0001, c);
    check(c == 32'h6, "R2 cmd after write ack", c, 6);
    check(ops == o + 1, "R4 one request per write", ops, o + 1);
    check(mem[32'h10] == 32'hCAFE_0001, "R2 downstream write data", mem[32'h10], 32'hCAFE_0001);
    host_read(12'h408, d); check(d == 0, "R2 write leaves read data", d, 0);

    // R5 / R7: ack cannot be written and nonzero writes are ignored
    host_write(12'h400, 32'h4);
    host_read(12'h400, c); check(c == 32'h6, "R5 bit2 write in ack", c, 6);
    host_write(12'h400, 32'h1);
    host_read(12'h400, c); check(c == 32'h6, "R7 new cmd in ack", c, 6);
    check(ops == o + 1, "R7 no extra request", ops, o + 1);

    // R6: clear
    host_write(12'h400, 32'h0);
    host_read(12'h400, c); check(c == 0, "R6 cmd after clear", c, 0);

    // R5: bit 2 alone in idle sets nothing
    host_write(12'h400, 32'h4);
    host_read(12'h400, c); check(c == 0, "R5 bit2 write in idle", c, 0);

    // R3: read transfer
    o = ops;
    do_read(32'h10, c, d);
    check(c == 32'h5, "R3 cmd after read ack", c, 5);
    check(d == 32'hCAFE_0001, "R3 read data", d, 32'hCAFE_0001);
    check(ops == o + 1, "R4 one request per read", ops, o + 1);
    host_write(12'h400, 32'h0);

    // R8: both bits is a no-op
    o = ops;
    host_write(12'h400, 32'h3);
    host_read(12'h400, c); check(c == 0, "R8 both bits", c, 0);
    tick(); tick();
    check(ops == o, "R8 no request", ops, o);

    // R7 / R10 / R12: stray writes while busy
    o = ops;
    host_write(12'h404, 32'h20);
    host_write(12'h400, 32'h1);
    host_write(12'h400, 32'h0);       // R12 zero while pending
    host_write(12'h404, 32'h30);      // R10 addr while busy
    host_write(12'h400, 32'h2);       // R7 new command while busy
    wait_ack(c);
    check(c == 32'h5, "R12 read completes after zero write", c, 5);
    check(ops == o + 1, "R7 single request while busy", ops, o + 1);
    check(r_addr == 12'h20, "R10 downstream addr kept", r_addr, 32'h20);
    host_read(12'h404, c); check(c == 32'h20, "R10 addr register unchanged", c, 32'h20);
    host_read(12'h408, d); check(d == (32'h5A00_0000 | 32'h20), "R3 default read", d, 32'h5A00_0020);
    host_write(12'h400, 32'h0);

    // R9: out-of-span read and write, and last in-span address
    o = ops;
    do_read(32'h1000, c, d);
    check(c == 32'h5, "R9 oob read ack", c, 5);
    check(d == 0, "R9 oob read data", d, 0);
    check(ops == o, "R9 oob read not forwarded", ops, o);
    host_write(12'h400, 32'h0);
    do_write(32'hFFFF_0010, 32'h1111_2222, c);
    check(c == 32'h6, "R9 oob write ack", c, 6);
    check(ops == o, "R9 oob write not forwarded", ops, o);
    check(mem[32'h10] == 32'hCAFE_0001, "R9 oob write left target", mem[32'h10], 32'hCAFE_0001);
    host_write(12'h400, 32'h0);
    do_write(32'hFFC, 32'h0BAD_F00D, c);
    check(ops == o + 1, "R9 edge address forwarded", ops, o + 1);
    check(mem[32'hFFC] == 32'h0BAD_F00D, "R9 edge write", mem[32'hFFC], 32'h0BAD_F00D);
    host_write(12'h400, 32'h0);

    // R2 / R3: mixed traffic with varying delays
    for (int i = 0; i < 6; i++) begin
      logic [31:0] a, v;
      a = 32'(i * 8 + 4);
      v = 32'h7700_0000 + 32'(i * 3);
      do_write(a, v, c);
      check(c == 32'h6, "R2 loop write ack", c, 6);
      host_write(12'h400, 32'h0);
      do_read(a, c, d);
      check(d == v, "R3 loop read back", d, v);
      host_write(12'h400, 32'h0);
    end

    // R11: reset while acknowledged
    do_write(32'h40, 32'h4242_4242, c);
    rst = 1; tick(); tick(); rst = 0;
    host_read(12'h400, c); check(c == 0, "R11 cmd after mid reset", c, 0);
    host_read(12'h40C, c); check(c == 0, "R11 wdata after mid reset", c, 0);

    done = 1;
    finish_run();
  end
endmodule